// File: doc/BRIEF.md
# Index and Stack Pointer Unit

This block keeps a 16-bit index register and a 16-bit stack pointer for a byte-wide processor core. A decoder hands it one operation at a time as a 4-bit code, together with a 16-bit operand, which is a memory address for word loads and stores and a comparison value for the index compare. For a push it also receives the byte to be pushed. The unit reaches a synchronous byte memory through its own port. Read data arrives in the cycle after a read strobe.

The stack pointer always holds the next free byte. A push therefore writes first and then moves the pointer down. A pull moves the pointer up first and then reads. For the same reason, transfers between the two registers add or remove one. Words are stored with the high byte at the lower address. Operations that only touch registers finish in one cycle. Memory operations hold `busy` until the last byte has been transferred. Every operation ends with a `done` pulse.

Top module: `idxsp_unit`

## Requirements
- R1: After a synchronous active-low reset, the index register is 0x0000, the stack pointer is SP_INIT (default 0x01FF), N/Z/V are 0, and `busy`, `done`, `mem_we` and `mem_re` are all low.
- R2: Push (code 7) writes `push_data` to the address held in the stack pointer during one write cycle, then decrements the stack pointer by one. `done` is high in the cycle after that write.
- R3: Pull (code 8) increments the stack pointer first, then reads the byte at the new address into `pull_out`, with `done` two cycles after acceptance. It issues no memory write, so the byte stays in place and the next push writes that same address.
- R4: Increment (code 1) and decrement (code 2) of the index register wrap modulo 2^16. They set Z when the new value is zero and leave N and V unchanged.
- R5: Increment (code 3) and decrement (code 4) of the stack pointer wrap modulo 2^16 and leave all flags unchanged.
- R6: Index-to-stack transfer (code 5) loads the stack pointer with index minus one. Stack-to-index transfer (code 6) loads the index register with stack pointer plus one. Both leave the flags unchanged.
- R7: A word load into the index register (code 9) or the stack pointer (code 10) reads the high byte from `operand` and the low byte from `operand`+1, in two consecutive read cycles. `done` follows three cycles after acceptance.
- R8: A word store of the index register (code 11) or the stack pointer (code 12) writes the high byte to `operand` and the low byte to `operand`+1, in two consecutive write cycles. `done` follows two cycles after acceptance. Write and read strobes are never high together.
- R9: Index compare (code 13) forms index minus `operand` without storing it. N is bit 15 of the difference, Z is set for a zero difference, and V flags two's complement overflow. The index register is not changed.
- R10: An operation presented while `busy` is high is ignored. Register-only operations assert `done` in the cycle after acceptance. `done` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present, taken when not busy |
| op_code | input | 4 | Operation code |
| operand | input | 16 | Address for word load/store, value for compare |
| push_data | input | 8 | Byte to push |
| busy | output | 1 | Memory operation in progress |
| done | output | 1 | One-cycle completion pulse |
| idx_out | output | 16 | Index register |
| sp_out | output | 16 | Stack pointer |
| pull_out | output | 8 | Last byte pulled |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_re` |

## Verification
The stack is exercised with two pushes followed by two pulls. This separates write-then-decrement from decrement-then-write, and increment-then-read from read-then-increment. A third push reveals whether a pull overwrote memory. Word transfers use distinct high and low bytes, so a byte swap or a wrong second address is visible. The compare is run on four operand pairs: a positive overflow, an equal pair, a plain negative result and a negative overflow. Between them these tell the N, Z and V flags apart. Increments and decrements are driven across the 0xFFFF/0x0000 boundary, both with the flags preset to 1 and with an operation injected while busy.

// File: rtl/idxsp_pkg.sv
`timescale 1ns/1ps
// Shared types for the index/stack pointer unit.
// Assumes a 4-bit operation code supplied by an external decoder.
package idxsp_pkg;
    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_INCX = 4'd1,
        OP_DECX = 4'd2,
        OP_INCS = 4'd3,
        OP_DECS = 4'd4,
        OP_XTOS = 4'd5,
        OP_STOX = 4'd6,
        OP_PUSH = 4'd7,
        OP_PULL = 4'd8,
        OP_LDX  = 4'd9,
        OP_LDS  = 4'd10,
        OP_STX  = 4'd11,
        OP_STS  = 4'd12,
        OP_CMPX = 4'd13
    } idx_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_FIRST   = 2'd1,
        SQ_SECOND  = 2'd2,
        SQ_CAPTURE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/idxsp_cmp.sv
`timescale 1ns/1ps
// Flag generator for the index compare: subtracts b from a and
// reports negative, zero and two's complement overflow.
// Purely combinational; the caller decides when flags are stored.
module idxsp_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         n,
    output logic         z,
    output logic         v
);
    logic [W-1:0] diff;

    // Difference and flags of a - b.
    always_comb begin
        diff = a - b;
        n    = diff[W-1];
        z    = (diff == '0);
        v    = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/idxsp_seq.sv
`timescale 1ns/1ps
// Memory sequencer: runs push, pull, word load and word store over a
// synchronous byte port (read data one cycle after the read strobe).
// Assumes start is only raised while idle. Words are high byte first.
module idxsp_seq
    import idxsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  idx_op_e               op_in,
    input  logic [2*DATA_W-1:0]   operand,
    input  logic [DATA_W-1:0]     push_data,
    input  logic [2*DATA_W-1:0]   x_val,
    input  logic [2*DATA_W-1:0]   sp_val,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  mem_we,
    output logic                  mem_re,
    output logic                  busy,
    output logic                  fin,
    output idx_op_e               op_cur,
    output logic [2*DATA_W-1:0]   rd_word
);
    localparam int AW = 2 * DATA_W;

    seq_state_e          state_q;
    idx_op_e             op_q;
    logic [AW-1:0]       base_q;
    logic [AW-1:0]       word_q;
    logic [DATA_W-1:0]   hi_q;
    logic                is_write;

    // State, latched operation, base address and outgoing data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            op_q    <= OP_NONE;
            base_q  <= '0;
            word_q  <= '0;
            hi_q    <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (start) begin
                    op_q    <= op_in;
                    state_q <= SQ_FIRST;
                    case (op_in)
                        OP_PUSH: begin
                            base_q <= sp_val;
                            word_q <= {{DATA_W{1'b0}}, push_data};
                        end
                        OP_PULL: base_q <= sp_val + AW'(1);
                        OP_STX: begin
                            base_q <= operand;
                            word_q <= x_val;
                        end
                        OP_STS: begin
                            base_q <= operand;
                            word_q <= sp_val;
                        end
                        default: base_q <= operand;
                    endcase
                end
                SQ_FIRST: begin
                    if (op_q == OP_PUSH)      state_q <= SQ_IDLE;
                    else if (op_q == OP_PULL) state_q <= SQ_CAPTURE;
                    else                      state_q <= SQ_SECOND;
                end
                SQ_SECOND: begin
                    hi_q    <= mem_rdata;
                    state_q <= is_write ? SQ_IDLE : SQ_CAPTURE;
                end
                SQ_CAPTURE: state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Memory strobes and completion, decoded from state only.
    always_comb begin
        is_write  = (op_q == OP_PUSH) || (op_q == OP_STX) || (op_q == OP_STS);
        mem_addr  = base_q;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        fin       = 1'b0;
        unique case (state_q)
            SQ_FIRST: begin
                mem_we    = is_write;
                mem_re    = !is_write;
                mem_wdata = (op_q == OP_PUSH) ? word_q[DATA_W-1:0] : word_q[AW-1:DATA_W];
                fin       = (op_q == OP_PUSH);
            end
            SQ_SECOND: begin
                mem_addr  = base_q + AW'(1);
                mem_we    = is_write;
                mem_re    = !is_write;
                mem_wdata = word_q[DATA_W-1:0];
                fin       = is_write;
            end
            SQ_CAPTURE: fin = 1'b1;
            default: ;
        endcase
    end

    assign busy    = (state_q != SQ_IDLE);
    assign op_cur  = op_q;
    assign rd_word = {hi_q, mem_rdata};

    // Guards for the byte port.
    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    assert_second_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SECOND) |-> (mem_addr == $past(mem_addr) + AW'(1)));
    assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);
endmodule

// File: rtl/idxsp_unit.sv
`timescale 1ns/1ps
// Index and stack pointer unit: holds both 16-bit registers and the
// N/Z/V flags, runs register-only operations in one cycle and hands
// memory operations to the sequencer. The stack pointer marks the
// next free byte. Assumes one operation is offered at a time.
module idxsp_unit
    import idxsp_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SP_INIT = 'h01FF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [3:0]          op_code,
    input  logic [2*DATA_W-1:0] operand,
    input  logic [DATA_W-1:0]   push_data,
    output logic                busy,
    output logic                done,
    output logic [2*DATA_W-1:0] idx_out,
    output logic [2*DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0]   pull_out,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_v,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int AW = 2 * DATA_W;

    idx_op_e           op_in;
    logic              accept;
    logic              is_mem;
    logic [AW-1:0]     x_q, sp_q;
    logic [AW-1:0]     x_inc, x_dec, sp_inc, sp_dec;
    logic [DATA_W-1:0] pull_q;
    logic              n_q, z_q, v_q, done_q;
    logic              cmp_n, cmp_z, cmp_v;
    logic              seq_busy, seq_fin;
    idx_op_e           seq_op;
    logic [AW-1:0]     seq_word;

    // Decode and step values for the current operation.
    always_comb begin
        op_in  = idx_op_e'(op_code);
        accept = op_valid && !seq_busy;
        is_mem = (op_in == OP_PUSH) || (op_in == OP_PULL) || (op_in == OP_LDX) ||
                 (op_in == OP_LDS)  || (op_in == OP_STX)  || (op_in == OP_STS);
        x_inc  = x_q + AW'(1);
        x_dec  = x_q - AW'(1);
        sp_inc = sp_q + AW'(1);
        sp_dec = sp_q - AW'(1);
    end

    idxsp_cmp #(.W(AW)) u_cmp (
        .a (x_q),
        .b (operand),
        .n (cmp_n),
        .z (cmp_z),
        .v (cmp_v)
    );

    idxsp_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && is_mem),
        .op_in     (op_in),
        .operand   (operand),
        .push_data (push_data),
        .x_val     (x_q),
        .sp_val    (sp_q),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .busy      (seq_busy),
        .fin       (seq_fin),
        .op_cur    (seq_op),
        .rd_word   (seq_word)
    );

    // Register file: one-cycle operations on accept, memory results on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            sp_q   <= AW'(SP_INIT);
            pull_q <= '0;
            n_q    <= 1'b0;
            z_q    <= 1'b0;
            v_q    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                done_q <= !is_mem;
                case (op_in)
                    OP_INCX: begin x_q <= x_inc; z_q <= (x_inc == '0); end
                    OP_DECX: begin x_q <= x_dec; z_q <= (x_dec == '0); end
                    OP_INCS: sp_q <= sp_inc;
                    OP_DECS: sp_q <= sp_dec;
                    OP_XTOS: sp_q <= x_dec;
                    OP_STOX: x_q  <= sp_inc;
                    OP_PULL: sp_q <= sp_inc;
                    OP_CMPX: begin n_q <= cmp_n; z_q <= cmp_z; v_q <= cmp_v; end
                    default: ;
                endcase
            end
            if (seq_fin) begin
                done_q <= 1'b1;
                case (seq_op)
                    OP_PUSH: sp_q   <= sp_dec;
                    OP_PULL: pull_q <= mem_rdata;
                    OP_LDX:  x_q    <= seq_word;
                    OP_LDS:  sp_q   <= seq_word;
                    default: ;
                endcase
            end
        end
    end

    assign busy     = seq_busy;
    assign done     = done_q;
    assign idx_out  = x_q;
    assign sp_out   = sp_q;
    assign pull_out = pull_q;
    assign flag_n   = n_q;
    assign flag_z   = z_q;
    assign flag_v   = v_q;

    // Stack ordering and flag-preservation guards.
    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fin && seq_op == OP_PUSH) |=> (sp_q == $past(sp_q) - AW'(1)));
    assert_pull_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && seq_op == OP_PULL) |-> (mem_addr == sp_q));
    assert_pull_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && seq_op == OP_PULL) |-> !mem_we);
    assert_sp_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op_in == OP_INCS || op_in == OP_DECS || op_in == OP_XTOS || op_in == OP_STOX))
        |=> $stable({n_q, z_q, v_q}));
    assert_cmp_keeps_x_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_in == OP_CMPX) |=> $stable(x_q));
    assert_no_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !done_q);
endmodule

// File: tb/idxsp_unit_bench.sv
`timescale 1ns/1ps
module idxsp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [15:0] operand = 16'h0;
    logic [7:0]  push_data = 8'h0;
    logic        busy, done;
    logic [15:0] idx_out, sp_out, mem_addr;
    logic [7:0]  pull_out, mem_wdata;
    logic [7:0]  mem_rdata = 8'h0;
    logic        flag_n, flag_z, flag_v, mem_we, mem_re;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    logic [15:0] last_wr_addr = 16'h0;
    logic [7:0]  bmem [0:255];

    always #4 clk = ~clk;

    idxsp_unit u_idxsp_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .push_data(push_data), .busy(busy), .done(done),
        .idx_out(idx_out), .sp_out(sp_out), .pull_out(pull_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // Synchronous byte memory model with a write log.
    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
            last_wr_addr <= mem_addr;
        end
        if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // Issue one operation and wait for done; waits counts negedges after acceptance.
    task automatic run(input logic [3:0] op, input logic [15:0] opd,
                       input logic [7:0] pd, output int waits);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; operand = opd; push_data = pd;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
        waits = 0;
        while (!done && waits < 20) begin
            @(negedge clk);
            waits++;
        end
    endtask

    task automatic t_reset();
        check("R1 idx", idx_out, 16'h0000);
        check("R1 sp", sp_out, 16'h01FF);
        check("R1 flags", {flag_n, flag_z, flag_v}, 3'b000);
        check("R1 strobes", {busy, done, mem_we, mem_re}, 4'b0000);
    endtask

    task automatic t_load();
        int w;
        run(4'd9, 16'h0010, 8'h0, w);
        check("R7 ldx value", idx_out, 16'hBEEF);
        check("R7 ldx latency", w, 3);
        run(4'd10, 16'h0012, 8'h0, w);
        check("R7 lds value", sp_out, 16'h1357);
    endtask

    task automatic t_store();
        int w;
        run(4'd11, 16'h0020, 8'h0, w);
        check("R8 stx latency", w, 2);
        check("R8 stx bytes", {bmem[8'h20], bmem[8'h21]}, 16'hBEEF);
        run(4'd12, 16'h0030, 8'h0, w);
        check("R8 sts bytes", {bmem[8'h30], bmem[8'h31]}, 16'h1357);
    endtask

    task automatic t_compare();
        int w;
        bmem[8'h40] = 8'h80; bmem[8'h41] = 8'h00;
        run(4'd9, 16'h0040, 8'h0, w);
        run(4'd13, 16'h0001, 8'h0, w);
        check("R9 pos overflow", {flag_n, flag_z, flag_v}, 3'b001);
        check("R9 x kept", idx_out, 16'h8000);
        run(4'd13, 16'h8000, 8'h0, w);
        check("R9 equal", {flag_n, flag_z, flag_v}, 3'b010);
        run(4'd13, 16'h8001, 8'h0, w);
        check("R9 negative", {flag_n, flag_z, flag_v}, 3'b100);
        bmem[8'h42] = 8'h7F; bmem[8'h43] = 8'hFF;
        run(4'd9, 16'h0042, 8'h0, w);
        run(4'd13, 16'hFFFF, 8'h0, w);
        check("R9 neg overflow", {flag_n, flag_z, flag_v}, 3'b101);
    endtask

    task automatic t_incdec_x();
        int w;
        bmem[8'h44] = 8'hFF; bmem[8'h45] = 8'hFF;
        run(4'd9, 16'h0044, 8'h0, w);
        run(4'd1, 16'h0, 8'h0, w);
        check("R4 incx wrap", idx_out, 16'h0000);
        check("R4 incx flags", {flag_n, flag_z, flag_v}, 3'b111);
        check("R10 one-cycle done", w, 0);
        run(4'd2, 16'h0, 8'h0, w);
        check("R4 decx wrap", idx_out, 16'hFFFF);
        check("R4 decx flags", {flag_n, flag_z, flag_v}, 3'b101);
    endtask

    task automatic t_incdec_sp();
        int w;
        bmem[8'h46] = 8'h00; bmem[8'h47] = 8'h00;
        run(4'd10, 16'h0046, 8'h0, w);
        run(4'd4, 16'h0, 8'h0, w);
        check("R5 decs wrap", sp_out, 16'hFFFF);
        run(4'd3, 16'h0, 8'h0, w);
        check("R5 incs wrap", sp_out, 16'h0000);
        check("R5 flags kept", {flag_n, flag_z, flag_v}, 3'b101);
    endtask

    task automatic t_transfer();
        int w;
        bmem[8'h48] = 8'h12; bmem[8'h49] = 8'h34;
        run(4'd9, 16'h0048, 8'h0, w);
        run(4'd5, 16'h0, 8'h0, w);
        check("R6 x to sp", sp_out, 16'h1233);
        bmem[8'h4A] = 8'h00; bmem[8'h4B] = 8'h40;
        run(4'd10, 16'h004A, 8'h0, w);
        run(4'd6, 16'h0, 8'h0, w);
        check("R6 sp to x", idx_out, 16'h0041);
        check("R6 flags kept", {flag_n, flag_z, flag_v}, 3'b101);
    endtask

    task automatic t_push_pull();
        int w;
        int wc;
        bmem[8'h4C] = 8'h00; bmem[8'h4D] = 8'h50;
        run(4'd10, 16'h004C, 8'h0, w);
        run(4'd7, 16'h0, 8'hA5, w);
        check("R2 push latency", w, 1);
        check("R2 push addr", last_wr_addr, 16'h0050);
        check("R2 push byte", bmem[8'h50], 8'hA5);
        check("R2 sp after push", sp_out, 16'h004F);
        run(4'd7, 16'h0, 8'h3C, w);
        check("R2 second push", {bmem[8'h4F], sp_out}, {8'h3C, 16'h004E});
        wc = wr_cnt;
        run(4'd8, 16'h0, 8'h0, w);
        check("R3 pull byte", pull_out, 8'h3C);
        check("R3 pull latency", w, 2);
        check("R3 sp after pull", sp_out, 16'h004F);
        run(4'd8, 16'h0, 8'h0, w);
        check("R3 second pull", {pull_out, sp_out}, {8'hA5, 16'h0050});
        check("R3 no writes", wr_cnt, wc);
        check("R3 byte kept", bmem[8'h4F], 8'h3C);
        run(4'd7, 16'h0, 8'h77, w);
        check("R3 push reuses slot", last_wr_addr, 16'h0050);
    endtask

    task automatic t_busy_ignore();
        int w;
        logic [15:0] x0;
        x0 = idx_out;
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd11; operand = 16'h0060;
        @(negedge clk);
        op_code = 4'd1;
        check("R10 busy", busy, 1'b1);
        check("R10 no done while busy", done, 1'b0);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
        w = 0;
        while (!done && w < 20) begin @(negedge clk); w++; end
        @(negedge clk);
        check("R10 ignored op", idx_out, x0);
    endtask

    initial begin
        int w;
        bmem[8'h10] = 8'hBE; bmem[8'h11] = 8'hEF;
        bmem[8'h12] = 8'h13; bmem[8'h13] = 8'h57;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_store();
        t_compare();
        t_incdec_x();
        t_incdec_sp();
        t_transfer();
        t_push_pull();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule